// File: doc/BRIEF.md
# Soft-Switch I/O Page Responder

This block answers processor accesses to one 256-byte I/O page, the page whose upper address byte is 0xC0 by default, so 0xC000 to 0xC0FF. The low address byte picks one of 256 offsets. Each offset can own an external read handler and an external write handler. The block sends the access to them through a single index bus with separate read and write enables. The switch side effects live outside the block, and so does the logic that produces the floating-bus value.

Every offset has a configuration entry with three fields: a read-handler-present flag, a write-handler-present flag and a driven-bits mode. The mode says which data bits the read handler really drives. The block fills the remaining bits from the floating-bus input, so each read result is a bitwise merge and not a plain select. An entry is loaded through a configuration port, one offset per cycle. Every access inside the page, with or without a handler, also raises a one-cycle event pulse on that offset's line. External switch logic can use the pulse to toggle state on any access.

Top module: `swpage_io`

## Requirements
- R1: After reset every offset has no read handler, no write handler and mode 0. `rd_valid`, `rd_evt` and `wr_evt` are all zero.
- R2: An access hits the page only when `bus_addr[15:8]` equals the page number (default 0xC0). The offset is `bus_addr[7:0]`. A strobe outside the page raises no handler enable, no `rd_valid` and no event pulse.
- R3: When `cfg_we` is high, the entry at `cfg_idx` takes `cfg_rd_on`, `cfg_wr_on` and `cfg_mode` at the clock edge. An access in the same cycle still sees the old entry. Accesses from the next cycle on see the new entry.
- R4: For an offset that has a read handler, mode code 0 returns the floating-bus byte. Code 1 returns handler bit 7 with floating-bus bits 6..0. Codes 2 and 3 return the handler byte unchanged. In general the result is (handler AND mask) OR (floating AND NOT mask), with mask 0x00, 0x80 or 0xFF.
- R5: A read of an offset with no read handler returns the floating-bus byte whatever its mode, and leaves `hnd_rd_en` low.
- R6: An in-page read with a handler present raises `hnd_rd_en` in the same cycle, with `hnd_idx` set to the offset. The merged byte appears on `rd_data` with `rd_valid` high for exactly one cycle, starting at the clock edge after the strobe.
- R7: An in-page write to an offset with a write handler raises `hnd_wr_en` in the same cycle, with `hnd_idx` set to the offset and `hnd_wdata` equal to `bus_wdata`. A write to an offset without a write handler raises no `hnd_wr_en`.
- R8: Every in-page read (or write) sets bit [offset] of `rd_evt` (or `wr_evt`) for the one cycle after the strobe, whether or not a handler is present. All other bits stay zero.
- R9: A read and a write strobe in the same cycle are both served: both handler enables, the read result and both event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Access address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| fbus_data | input | 8 | Floating-bus byte for undriven bits |
| rd_data | output | 8 | Merged read result |
| rd_valid | output | 1 | Read result valid, one cycle |
| hnd_idx | output | 8 | Offset index for the handlers |
| hnd_rd_en | output | 1 | Read handler enable |
| hnd_rdata | input | 8 | Data from the selected read handler |
| hnd_wr_en | output | 1 | Write handler enable |
| hnd_wdata | output | 8 | Data to the selected write handler |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Offset being configured |
| cfg_rd_on | input | 1 | Read handler present |
| cfg_wr_on | input | 1 | Write handler present |
| cfg_mode | input | 2 | Driven-bits mode code |
| rd_evt | output | 256 | Per-offset read event pulses |
| wr_evt | output | 256 | Per-offset write event pulses |

## Verification
The assertions assume a few things about the inputs. `bus_addr`, `bus_wdata` and the strobes are known and steady around each edge. `hnd_rdata` stands for the handler chosen by the current `hnd_idx`. A configuration write may land in the same cycle as an access to the same offset. The stimulus meets these assumptions by driving every input at the falling edge and holding it through the rising edge. Random addresses fall inside the page most of the time and outside it occasionally. Mode codes are drawn over the full two-bit range. Directed cases cover a configuration write that collides with an access, and a read and a write in the same cycle.

// File: rtl/swpage_pkg.sv
package swpage_pkg;

   // Driven-bits mode codes (code 3 behaves like MODE_ALL)
   typedef enum logic [1:0] {
      MODE_NONE = 2'd0,
      MODE_TOP  = 2'd1,
      MODE_ALL  = 2'd2,
      MODE_ALT  = 2'd3
   } drive_mode_e;

   typedef struct packed {
      logic        rd_on;
      logic        wr_on;
      drive_mode_e mode;
   } page_ent_t;

   localparam page_ent_t ENT_EMPTY = '{rd_on: 1'b0, wr_on: 1'b0, mode: MODE_NONE};

endpackage

// File: rtl/swpage_cfg_tbl.sv
module swpage_cfg_tbl
   import swpage_pkg::*;
#(
   parameter int OFS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [OFS_W-1:0] cfg_idx,
   input  page_ent_t        cfg_ent,
   input  logic [OFS_W-1:0] look_idx,
   output page_ent_t        look_ent
);
   localparam int NUM_OFS = 1 << OFS_W;

   page_ent_t tbl [NUM_OFS];

   // One register per offset; write select is a simple index compare
   for (genvar g = 0; g < NUM_OFS; g++) begin : g_ent
      page_ent_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= ENT_EMPTY;
         else if (cfg_we && (cfg_idx == OFS_W'(g)))
            q <= cfg_ent;
      end
      assign tbl[g] = q;
   end

   assign look_ent = tbl[look_idx];

endmodule

// File: rtl/swpage_merge.sv
module swpage_merge
   import swpage_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  page_ent_t         ent,
   input  logic [DATA_W-1:0] hnd_data,
   input  logic [DATA_W-1:0] flt_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam logic [DATA_W-1:0] TOP_MASK = DATA_W'(1) << (DATA_W - 1);
   localparam logic [DATA_W-1:0] ALL_MASK = '1;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] merged;

   always_comb begin
      mask = '0;
      if (ent.rd_on) begin
         unique case (ent.mode)
            MODE_NONE: mask = '0;
            MODE_TOP:  mask = TOP_MASK;
            MODE_ALL,
            MODE_ALT:  mask = ALL_MASK;
            default:   mask = '0;
         endcase
      end
   end

   // Bitwise merge: per bit, handler when driven, floating otherwise
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign merged[b] = mask[b] ? hnd_data[b] : flt_data[b];
   end

   if (READ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
         end else begin
            rd_valid <= rd_go;
            if (rd_go)
               rd_data <= merged;
         end
      end
   end else begin : g_comb
      assign rd_data  = rd_go ? merged : '0;
      assign rd_valid = rd_go;
   end

endmodule

// File: rtl/swpage_evt.sv
module swpage_evt #(
   parameter int OFS_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_hit,
   input  logic                  wr_hit,
   input  logic [OFS_W-1:0]      ofs,
   output logic [(1<<OFS_W)-1:0] rd_evt,
   output logic [(1<<OFS_W)-1:0] wr_evt
);
   localparam int NUM_OFS = 1 << OFS_W;

   for (genvar g = 0; g < NUM_OFS; g++) begin : g_line
      logic sel;
      assign sel = (ofs == OFS_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_evt[g] <= 1'b0;
            wr_evt[g] <= 1'b0;
         end else begin
            rd_evt[g] <= rd_hit && sel;
            wr_evt[g] <= wr_hit && sel;
         end
      end
   end

endmodule

// File: rtl/swpage_io.sv
module swpage_io
   import swpage_pkg::*;
#(
   parameter int                         ADDR_W   = 16,
   parameter int                         OFS_W    = 8,
   parameter int                         DATA_W   = 8,
   parameter logic [ADDR_W-OFS_W-1:0]    PAGE_HI  = 'hC0,
   parameter bit                         READ_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic [DATA_W-1:0]     fbus_data,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_valid,
   output logic [OFS_W-1:0]      hnd_idx,
   output logic                  hnd_rd_en,
   input  logic [DATA_W-1:0]     hnd_rdata,
   output logic                  hnd_wr_en,
   output logic [DATA_W-1:0]     hnd_wdata,
   input  logic                  cfg_we,
   input  logic [OFS_W-1:0]      cfg_idx,
   input  logic                  cfg_rd_on,
   input  logic                  cfg_wr_on,
   input  logic [1:0]            cfg_mode,
   output logic [(1<<OFS_W)-1:0] rd_evt,
   output logic [(1<<OFS_W)-1:0] wr_evt
);
   localparam int HI_W = ADDR_W - OFS_W;

   if (OFS_W < 1 || OFS_W > 10) begin : g_bad_ofs
      $error("swpage_io: OFS_W must lie in 1..10");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("swpage_io: ADDR_W must exceed OFS_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("swpage_io: DATA_W must be at least 2");
   end

   logic [HI_W-1:0]  addr_hi;
   logic [OFS_W-1:0] ofs;
   logic             in_page;
   logic             rd_hit;
   logic             wr_hit;
   page_ent_t        cur_ent;
   page_ent_t        new_ent;

   assign addr_hi = bus_addr[ADDR_W-1:OFS_W];
   assign ofs     = bus_addr[OFS_W-1:0];
   assign in_page = (addr_hi == PAGE_HI);
   assign rd_hit  = bus_rd && in_page;
   assign wr_hit  = bus_wr && in_page;

   assign new_ent = '{rd_on: cfg_rd_on, wr_on: cfg_wr_on, mode: drive_mode_e'(cfg_mode)};

   swpage_cfg_tbl #(.OFS_W(OFS_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_idx  (cfg_idx),
      .cfg_ent  (new_ent),
      .look_idx (ofs),
      .look_ent (cur_ent)
   );

   // Handler dispatch
   assign hnd_idx   = ofs;
   assign hnd_rd_en = rd_hit && cur_ent.rd_on;
   assign hnd_wr_en = wr_hit && cur_ent.wr_on;
   assign hnd_wdata = bus_wdata;

   swpage_merge #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_go    (rd_hit),
      .ent      (cur_ent),
      .hnd_data (hnd_rdata),
      .flt_data (fbus_data),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   swpage_evt #(.OFS_W(OFS_W)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit),
      .ofs    (ofs),
      .rd_evt (rd_evt),
      .wr_evt (wr_evt)
   );

endmodule

// File: rtl/swpage_io_chk.sv
module swpage_io_chk #(
   parameter int                      ADDR_W   = 16,
   parameter int                      OFS_W    = 8,
   parameter int                      DATA_W   = 8,
   parameter logic [ADDR_W-OFS_W-1:0] PAGE_HI  = 'hC0,
   parameter bit                      READ_REG = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_rd,
   input logic                  bus_wr,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic                  rd_valid,
   input logic [OFS_W-1:0]      hnd_idx,
   input logic                  hnd_rd_en,
   input logic                  hnd_wr_en,
   input logic [DATA_W-1:0]     hnd_wdata,
   input logic                  cfg_we,
   input logic [OFS_W-1:0]      cfg_idx,
   input logic                  cfg_rd_on,
   input logic [(1<<OFS_W)-1:0] rd_evt,
   input logic [(1<<OFS_W)-1:0] wr_evt
);
   localparam logic [(1<<OFS_W)-1:0] ONE = 1;

   logic pg;
   assign pg = (bus_addr[ADDR_W-1:OFS_W] == PAGE_HI);

   // R2: strobes outside the page reach no handler
   a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pg |-> (!hnd_rd_en && !hnd_wr_en));

   // R6: read handler enable only for an in-page read strobe
   a_r6_rd_en_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_rd_en |-> (bus_rd && pg && hnd_idx == bus_addr[OFS_W-1:0]));

   // R7: write handler enable carries the bus data
   a_r7_wr_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_wr_en |-> (bus_wr && pg && hnd_wdata == bus_wdata));

   // R8: at most one event line per direction
   a_r8_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_evt) && $onehot0(wr_evt));

   // R8: write event follows every in-page write
   a_r8_wr_evt_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && pg) |=> (wr_evt == (ONE << $past(bus_addr[OFS_W-1:0]))));

   // R8: no read event without an in-page read
   a_r8_rd_evt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && pg) |=> (rd_evt == '0));

   // R3: clearing the read flag takes effect on the next cycle
   a_r3_cfg_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_rd_on) |=> !(hnd_rd_en && hnd_idx == $past(cfg_idx)));

   if (READ_REG) begin : g_lat
      // R6: one registered read result per in-page read
      a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && pg) |=> rd_valid);
      a_r6_valid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
         !(bus_rd && pg) |=> !rd_valid);
   end

endmodule

bind swpage_io swpage_io_chk #(
   .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .PAGE_HI(PAGE_HI), .READ_REG(READ_REG)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .rd_valid  (rd_valid),
   .hnd_idx   (hnd_idx),
   .hnd_rd_en (hnd_rd_en),
   .hnd_wr_en (hnd_wr_en),
   .hnd_wdata (hnd_wdata),
   .cfg_we    (cfg_we),
   .cfg_idx   (cfg_idx),
   .cfg_rd_on (cfg_rd_on),
   .rd_evt    (rd_evt),
   .wr_evt    (wr_evt)
);

// File: tb/test_swpage_io.sv
`timescale 1ns/1ps
module test_swpage_io;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  bus_addr = '0;
   logic         bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]   bus_wdata = '0, fbus_data = '0, hnd_rdata = '0;
   logic [7:0]   rd_data, hnd_wdata, hnd_idx;
   logic         rd_valid, hnd_rd_en, hnd_wr_en;
   logic         cfg_we = 1'b0, cfg_rd_on = 1'b0, cfg_wr_on = 1'b0;
   logic [7:0]   cfg_idx = '0;
   logic [1:0]   cfg_mode = '0;
   logic [255:0] rd_evt, wr_evt;

   always #5 clk = ~clk;

   swpage_io i_swpage_io (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .fbus_data(fbus_data), .rd_data(rd_data), .rd_valid(rd_valid),
      .hnd_idx(hnd_idx), .hnd_rd_en(hnd_rd_en), .hnd_rdata(hnd_rdata), .hnd_wr_en(hnd_wr_en),
      .hnd_wdata(hnd_wdata), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rd_on(cfg_rd_on),
      .cfg_wr_on(cfg_wr_on), .cfg_mode(cfg_mode), .rd_evt(rd_evt), .wr_evt(wr_evt)
   );

   int n_chk = 0, n_err = 0;
   bit m_rd [256];
   bit m_wr [256];
   logic [1:0] m_mode [256];

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [7:0] off, input logic [7:0] hd, input logic [7:0] fb);
      if (!m_rd[off]) return fb;                  // R5
      case (m_mode[off])
         2'd0:    return fb;                      // R4 mask 0x00
         2'd1:    return {hd[7], fb[6:0]};        // R4 mask 0x80
         default: return hd;                      // R4 mask 0xFF
      endcase
   endfunction

   task automatic acc(input logic [15:0] a, input bit r, input bit w, input logic [7:0] wd,
                      input logic [7:0] hd, input logic [7:0] fb,
                      input bit cwe, input logic [7:0] cidx, input bit crd, input bit cwr,
                      input logic [1:0] cmode);
      bit in_pg;
      logic [7:0] off, exp_d;
      bit e_hre, e_hwe;
      string tag;
      @(negedge clk);
      bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = wd; hnd_rdata = hd; fbus_data = fb;
      cfg_we = cwe; cfg_idx = cidx; cfg_rd_on = crd; cfg_wr_on = cwr; cfg_mode = cmode;
      #1;
      in_pg = (a[15:8] == 8'hC0);
      off   = a[7:0];
      e_hre = r && in_pg && m_rd[off];
      e_hwe = w && in_pg && m_wr[off];
      exp_d = exp_read(off, hd, fb);
      tag   = in_pg ? (cwe && cidx == off ? "R3" : "R6") : "R2";
      chk(hnd_rd_en == e_hre, {tag, " hnd_rd_en"}, 256'(hnd_rd_en), 256'(e_hre));
      tag   = in_pg ? (cwe && cidx == off ? "R3" : "R7") : "R2";
      chk(hnd_wr_en == e_hwe, {tag, " hnd_wr_en"}, 256'(hnd_wr_en), 256'(e_hwe));
      if (e_hre || e_hwe)
         chk(hnd_idx == off, "R6 hnd_idx", 256'(hnd_idx), 256'(off));
      if (e_hwe)
         chk(hnd_wdata == wd, "R7 hnd_wdata", 256'(hnd_wdata), 256'(wd));
      @(posedge clk);
      #1;
      bus_rd = 1'b0; bus_wr = 1'b0; cfg_we = 1'b0;
      chk(rd_valid == (r && in_pg), in_pg ? "R6 rd_valid" : "R2 rd_valid",
          256'(rd_valid), 256'(r && in_pg));
      if (r && in_pg) begin
         tag = !m_rd[off] ? "R5" : (cwe && cidx == off ? "R3" : (w ? "R9" : "R4"));
         chk(rd_data == exp_d, {tag, " rd_data"}, 256'(rd_data), 256'(exp_d));
      end
      chk(rd_evt == ((r && in_pg) ? (256'd1 << off) : 256'd0), in_pg ? "R8 rd_evt" : "R2 rd_evt",
          rd_evt, (r && in_pg) ? (256'd1 << off) : 256'd0);
      chk(wr_evt == ((w && in_pg) ? (256'd1 << off) : 256'd0), in_pg ? "R8 wr_evt" : "R2 wr_evt",
          wr_evt, (w && in_pg) ? (256'd1 << off) : 256'd0);
      if (cwe) begin
         m_rd[cidx] = crd; m_wr[cidx] = cwr; m_mode[cidx] = cmode;
      end
   endtask

   task automatic cfg(input logic [7:0] idx, input bit crd, input bit cwr, input logic [1:0] md);
      acc(16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, idx, crd, cwr, md);
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] hd, input logic [7:0] fb);
      acc(a, 1'b1, 1'b0, 8'h00, hd, fb, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] wd);
      acc(a, 1'b0, 1'b1, wd, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 256; i++) begin m_rd[i] = 0; m_wr[i] = 0; m_mode[i] = 2'd0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: quiet outputs after reset, unconfigured offsets
      #1;
      chk(rd_valid == 1'b0, "R1 rd_valid", 256'(rd_valid), 256'd0);
      chk(rd_evt == '0 && wr_evt == '0, "R1 events", rd_evt | wr_evt, 256'd0);
      rd(16'hC005, 8'hA5, 8'h3C);   // R1 read gives floating value
      wr(16'hC0FF, 8'h77);          // R1 write discarded
      // R4 each mode code
      cfg(8'h10, 1, 1, 2'd0); rd(16'hC010, 8'hFF, 8'h12);
      cfg(8'h10, 1, 1, 2'd1); rd(16'hC010, 8'h80, 8'h7F); rd(16'hC010, 8'h7F, 8'hFF);
      cfg(8'h10, 1, 1, 2'd2); rd(16'hC010, 8'h5A, 8'hA5);
      cfg(8'h10, 1, 1, 2'd3); rd(16'hC010, 8'hC3, 8'h00);
      // R5 mode full but no read handler
      cfg(8'h20, 0, 1, 2'd2); rd(16'hC020, 8'h11, 8'hEE); wr(16'hC020, 8'h42);
      // R2 outside the page
      rd(16'hC110, 8'h55, 8'h66); wr(16'hBF10, 8'h12); rd(16'h0010, 8'h00, 8'h01);
      // R3 config colliding with an access to the same offset
      acc(16'hC030, 1, 1, 8'h9C, 8'hF0, 8'h0F, 1'b1, 8'h30, 1, 1, 2'd2);
      rd(16'hC030, 8'hF0, 8'h0F);
      acc(16'hC030, 1, 0, 8'h00, 8'hF0, 8'h0F, 1'b1, 8'h30, 0, 0, 2'd2);
      rd(16'hC030, 8'hF0, 8'h0F);
      // R9 read and write together, edge offsets
      cfg(8'h00, 1, 1, 2'd1); acc(16'hC000, 1, 1, 8'h3E, 8'h80, 8'h15, 0, 0, 0, 0, 0);
      cfg(8'hFF, 1, 1, 2'd2); acc(16'hC0FF, 1, 1, 8'hD1, 8'h69, 8'h96, 0, 0, 0, 0, 0);
      // Random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned op = $urandom_range(0, 9);
         logic [15:0] a;
         a = {($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hC0, 8'($urandom_range(0, 15) << 4 | $urandom_range(0, 3))};
         if (op < 3)
            cfg(a[7:0], 1'($urandom), 1'($urandom), 2'($urandom));
         else
            acc(a, op != 8, op >= 7, 8'($urandom), 8'($urandom), 8'($urandom),
                ($urandom_range(0, 7) == 0), a[7:0], 1'($urandom), 1'($urandom), 2'($urandom));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule